// File: doc/BRIEF.md
# Processor Cluster Power Controller

This block keeps the power state of a small multi-core system, by default two clusters of four cores, and drives one power-enable line per core and per cluster. Software reaches it through a 32-bit register port of five word-aligned slots. Each command slot takes a 24-bit core affinity identifier: bits 7:0 name the core inside its cluster, bits 15:8 name the cluster, and bits 23:16 must be zero.

A core is powered on by command. Power-off is requested by command but deferred: the request only marks the core or cluster as pending, and the actual switch-off happens when that core's standby-for-interrupt input, or the cluster's standby input, is seen while the request is pending. A per-core wake-enable flag lets a wake request input bring a suspended core back. Status is read indirectly: software writes an identifier to the status slot to select a core, and a read of that slot then returns the selected core's power flags and a 2-bit record of why it was last powered on. Illegal commands are dropped and leave a sticky error flag set.

All events seen in one clock cycle resolve together, in a fixed order: the bus command first, then wake requests, then core standby, then cluster standby, then the warm reset pin.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After reset only core 0 of cluster 0 and cluster 0 are powered; every core's reason is 00 (cold), every wake enable and pending flag is clear, and `prog_err` is 0.
- R2: An identifier is valid only when bits 23:16 are zero, bits 7:0 are below the cores-per-cluster count and bits 15:8 are below the cluster count; command-slot bits 30:24 are ignored. A command write (offsets 0x00, 0x04, 0x08, 0x0C) with an invalid identifier changes no state and sets `prog_err`.
- R3: A write to offset 0x04 naming a powered-off core powers that core and its cluster on at the next edge, clears the core's and the cluster's pending-off flags and sets the core's reason to 10.
- R4: A write to offset 0x00 naming a powered core sets its pending-off flag; the core switches off at the first edge where its `core_standby` bit is high while the flag is set, and the flag clears.
- R5: A write to offset 0x08 naming a core of a powered cluster sets that cluster's pending-off flag; at the first edge with the cluster's `cluster_standby` high while the flag is set, the cluster and all its cores switch off and all their pending-off flags clear.
- R6: A write to offset 0x0C with a valid identifier stores bit 31 as that core's wake enable, whether the core is on or off.
- R7: A `wake_req` bit for a powered-off core with wake enable set powers the core and its cluster on, clears the core's and cluster's pending-off flags and sets the reason to 11; with wake enable clear the request has no effect.
- R8: A write to offset 0x10 stores bits 23:0 as the status selection. While `bus_addr` is 0x10, `bus_rdata` shows the selected core as bit 30 cluster on, bit 29 core on, bit 28 wake enable, bit 27 cluster pending off, bit 26 core pending off, bits 25:24 reason, all other bits zero; an invalid selection and any other address read as zero.
- R9: When `warm_rst_req` is high at an edge, every core that is powered after that edge gets reason 01; other state is unchanged.
- R10: A processor-on write to a powered core, a processor-off write to an unpowered core, or a cluster-off write to an unpowered cluster is dropped and sets `prog_err`, which stays set until `rst_n`.
- R11: A core is never powered while its cluster is unpowered.
- R12: Same-cycle events resolve in order: a processor-off write together with the core's standby switches the core off at that edge; a power-on by command or wake clears pending flags before standby is looked at, so the core stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| core_standby | input | NCL*CPC | Per-core standby-for-interrupt indication |
| cluster_standby | input | NCL | Per-cluster standby indication |
| wake_req | input | NCL*CPC | Per-core wake request from the interrupt controller |
| warm_rst_req | input | 1 | Warm reset pin, records reason 01 for powered cores |
| core_pwr_en | output | NCL*CPC | Per-core power enable, core k is in cluster k/CPC |
| cluster_pwr_en | output | NCL | Per-cluster power enable |
| prog_err | output | 1 | Sticky programming-error flag |

## Verification
The hardest states to reach are those where several events land on the same edge: a deferred power-off meeting a standby pulse in the very cycle the request is written, a wake request for a core whose cluster is also about to drop, or a warm reset coinciding with a power-on. Directed sequences set up the pending flags first and then apply the coinciding pulses, and a long random phase drives writes with valid and invalid identifiers together with sparse standby, wake and warm-reset pulses, so that overlaps arise often; a behavioural model that applies the five event steps in order is compared with the outputs and the status read every cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int ADDR_W = 5;
  localparam int ID_W   = 24;

  // Register slot offsets; software depends on these values.
  localparam logic [ADDR_W-1:0] OFS_CORE_OFF = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CORE_ON  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CLUS_OFF = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_WAKE_CFG = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 5'h10;

  localparam int WEN_BIT = 31;

  typedef enum logic [1:0] {
    RSN_COLD = 2'b00,
    RSN_PIN  = 2'b01,
    RSN_CMD  = 2'b10,
    RSN_WAKE = 2'b11
  } pwr_reason_e;

endpackage

// File: rtl/pcc_id_match.sv
module pcc_id_match #(
  parameter int NCL = 2,
  parameter int CPC = 4
) (
  input  logic [23:0]          id,
  output logic                 id_ok,
  output logic [NCL*CPC-1:0]   core_hit,
  output logic [NCL-1:0]       clus_hit
);

  localparam int NCORE = NCL * CPC;

  logic [7:0] f_core;
  logic [7:0] f_clus;
  logic [7:0] f_top;

  assign f_core = id[7:0];
  assign f_clus = id[15:8];
  assign f_top  = id[23:16];

  assign id_ok = (f_top == 8'd0) && (int'(f_core) < CPC) && (int'(f_clus) < NCL);

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    assign core_hit[k] = id_ok && (int'(f_clus) == (k / CPC)) && (int'(f_core) == (k % CPC));
  end

  for (genvar c = 0; c < NCL; c++) begin : g_clus
    assign clus_hit[c] = id_ok && (int'(f_clus) == c);
  end

endmodule

// File: rtl/pcc_cmd_decode.sv
module pcc_cmd_decode
  import pcc_pkg::*;
#(
  parameter int NCL = 2,
  parameter int CPC = 4
) (
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [NCL*CPC-1:0]   core_on,
  input  logic [NCL-1:0]       clus_on,
  output logic [NCL*CPC-1:0]   ppoff_sel,
  output logic [NCL*CPC-1:0]   ppon_sel,
  output logic [NCL*CPC-1:0]   wkup_sel,
  output logic [NCL-1:0]       pcoff_sel,
  output logic                 wen_val,
  output logic                 sel_we,
  output logic                 cmd_err
);

  localparam int NCORE = NCL * CPC;

  logic                id_ok;
  logic [NCORE-1:0]    core_hit;
  logic [NCL-1:0]      clus_hit;
  logic                wr_off, wr_on, wr_coff, wr_wk, wr_cmd;
  logic                tgt_core_on, tgt_clus_on;
  logic                unused_hi;

  pcc_id_match #(.NCL(NCL), .CPC(CPC)) u_match (
    .id       (bus_wdata[ID_W-1:0]),
    .id_ok    (id_ok),
    .core_hit (core_hit),
    .clus_hit (clus_hit)
  );

  assign unused_hi = ^bus_wdata[30:24];

  assign wr_off  = bus_wr && (bus_addr == OFS_CORE_OFF);
  assign wr_on   = bus_wr && (bus_addr == OFS_CORE_ON);
  assign wr_coff = bus_wr && (bus_addr == OFS_CLUS_OFF);
  assign wr_wk   = bus_wr && (bus_addr == OFS_WAKE_CFG);
  assign wr_cmd  = wr_off | wr_on | wr_coff | wr_wk;
  assign sel_we  = bus_wr && (bus_addr == OFS_STATUS);
  assign wen_val = bus_wdata[WEN_BIT];

  assign tgt_core_on = |(core_hit & core_on);
  assign tgt_clus_on = |(clus_hit & clus_on);

  assign ppoff_sel = {NCORE{wr_off}} & core_hit & core_on;
  assign ppon_sel  = {NCORE{wr_on}}  & core_hit & ~core_on;
  assign wkup_sel  = {NCORE{wr_wk}}  & core_hit;
  assign pcoff_sel = {NCL{wr_coff}}  & clus_hit & clus_on;

  assign cmd_err = (wr_cmd && !id_ok)
                 | (wr_off  && id_ok && !tgt_core_on)
                 | (wr_on   && id_ok &&  tgt_core_on)
                 | (wr_coff && id_ok && !tgt_clus_on);

endmodule

// File: rtl/pcc_cluster_slice.sv
module pcc_cluster_slice #(
  parameter int CPC      = 4,
  parameter bit RESET_ON = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pcoff_sel,
  input  logic [CPC-1:0] core_up,
  input  logic           cl_standby,
  output logic           clus_on,
  output logic           clus_pend,
  output logic           clus_down
);

  logic any_up;
  logic on_a, pend_a;
  logic on_n, pend_n;
  logic st_en;

  always_comb begin
    any_up    = |core_up;
    on_a      = clus_on | any_up;
    pend_a    = any_up ? 1'b0 : (clus_pend | pcoff_sel);
    clus_down = cl_standby & pend_a & on_a;
    on_n      = on_a & ~clus_down;
    pend_n    = clus_down ? 1'b0 : pend_a;
    st_en     = any_up | pcoff_sel | cl_standby;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clus_on   <= RESET_ON;
      clus_pend <= 1'b0;
    end else if (st_en) begin
      clus_on   <= on_n;
      clus_pend <= pend_n;
    end
  end

endmodule

// File: rtl/pcc_core_slice.sv
module pcc_core_slice
  import pcc_pkg::*;
#(
  parameter bit RESET_ON = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ppoff_sel,
  input  logic        ppon_sel,
  input  logic        wkup_sel,
  input  logic        wen_val,
  input  logic        wake_req,
  input  logic        core_standby,
  input  logic        clus_down,
  input  logic        warm_rst,
  output logic        core_on,
  output logic        pend_off,
  output logic        wake_en,
  output pwr_reason_e reason,
  output logic        core_up
);

  logic        wen_n, wake_hit;
  logic        on_a, pend_a, sby_down, go_off;
  logic        on_n, pend_n;
  pwr_reason_e rsn_a, rsn_n;
  logic        st_en;

  always_comb begin
    wen_n    = wkup_sel ? wen_val : wake_en;
    wake_hit = wake_req & wen_n & ~core_on & ~ppon_sel;
    core_up  = ppon_sel | wake_hit;
    on_a     = core_on | core_up;
    pend_a   = core_up ? 1'b0 : (pend_off | ppoff_sel);
    sby_down = core_standby & pend_a & on_a;
    go_off   = sby_down | clus_down;
    on_n     = on_a & ~go_off;
    pend_n   = go_off ? 1'b0 : pend_a;
    if (ppon_sel)      rsn_a = RSN_CMD;
    else if (wake_hit) rsn_a = RSN_WAKE;
    else               rsn_a = reason;
    rsn_n    = (warm_rst && on_n) ? RSN_PIN : rsn_a;
    st_en    = ppoff_sel | ppon_sel | wkup_sel | wake_req | core_standby | clus_down | warm_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_on  <= RESET_ON;
      pend_off <= 1'b0;
      wake_en  <= 1'b0;
      reason   <= RSN_COLD;
    end else if (st_en) begin
      core_on  <= on_n;
      pend_off <= pend_n;
      wake_en  <= wen_n;
      reason   <= rsn_n;
    end
  end

endmodule

// File: rtl/cluster_pwr_ctrl.sv
module cluster_pwr_ctrl
  import pcc_pkg::*;
#(
  parameter int NCL = 2,
  parameter int CPC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [4:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCL*CPC-1:0]   core_standby,
  input  logic [NCL-1:0]       cluster_standby,
  input  logic [NCL*CPC-1:0]   wake_req,
  input  logic                 warm_rst_req,
  output logic [NCL*CPC-1:0]   core_pwr_en,
  output logic [NCL-1:0]       cluster_pwr_en,
  output logic                 prog_err
);

  localparam int NCORE = NCL * CPC;

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NCORE-1:0]  core_on, pend_off, wake_en, core_up;
  logic [NCORE-1:0]  ppoff_sel, ppon_sel, wkup_sel;
  logic [NCL-1:0]    pcoff_sel, clus_on, clus_pend, clus_down;
  pwr_reason_e       reason [NCORE];
  logic              wen_val, sel_we, cmd_err;

  pcc_cmd_decode #(.NCL(NCL), .CPC(CPC)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .core_on   (core_on),
    .clus_on   (clus_on),
    .ppoff_sel (ppoff_sel),
    .ppon_sel  (ppon_sel),
    .wkup_sel  (wkup_sel),
    .pcoff_sel (pcoff_sel),
    .wen_val   (wen_val),
    .sel_we    (sel_we),
    .cmd_err   (cmd_err)
  );

  for (genvar c = 0; c < NCL; c++) begin : g_clus
    pcc_cluster_slice #(.CPC(CPC), .RESET_ON(c == 0)) u_cl (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .pcoff_sel  (pcoff_sel[c]),
      .core_up    (core_up[c*CPC +: CPC]),
      .cl_standby (cluster_standby[c]),
      .clus_on    (clus_on[c]),
      .clus_pend  (clus_pend[c]),
      .clus_down  (clus_down[c])
    );
  end

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    pcc_core_slice #(.RESET_ON(k == 0)) u_core (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .ppoff_sel    (ppoff_sel[k]),
      .ppon_sel     (ppon_sel[k]),
      .wkup_sel     (wkup_sel[k]),
      .wen_val      (wen_val),
      .wake_req     (wake_req[k]),
      .core_standby (core_standby[k]),
      .clus_down    (clus_down[k / CPC]),
      .warm_rst     (warm_rst_req),
      .core_on      (core_on[k]),
      .pend_off     (pend_off[k]),
      .wake_en      (wake_en[k]),
      .reason       (reason[k]),
      .core_up      (core_up[k])
    );
  end

  // Status selection register and indirect read.
  logic [ID_W-1:0]   sel_id;
  logic              sel_ok;
  logic [NCORE-1:0]  sel_hit;
  logic [NCL-1:0]    sel_clus_hit;
  logic [31:0]       st_word [NCORE];
  logic [31:0]       status_word;
  logic              unused_sel;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_id <= '0;
    else if (sel_we)  sel_id <= bus_wdata[ID_W-1:0];
  end

  pcc_id_match #(.NCL(NCL), .CPC(CPC)) u_sel_match (
    .id       (sel_id),
    .id_ok    (sel_ok),
    .core_hit (sel_hit),
    .clus_hit (sel_clus_hit)
  );
  assign unused_sel = sel_ok ^ (^sel_clus_hit);

  for (genvar k = 0; k < NCORE; k++) begin : g_st
    assign st_word[k] = sel_hit[k]
      ? {1'b0, clus_on[k / CPC], core_on[k], wake_en[k], clus_pend[k / CPC],
         pend_off[k], reason[k], 24'd0}
      : 32'd0;
  end

  always_comb begin
    status_word = 32'd0;
    for (int k = 0; k < NCORE; k++) status_word = status_word | st_word[k];
  end

  assign bus_rdata = (bus_addr == OFS_STATUS) ? status_word : 32'd0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  prog_err <= 1'b0;
    else if (cmd_err) prog_err <= 1'b1;
  end

  assign core_pwr_en    = core_on;
  assign cluster_pwr_en = clus_on;

endmodule

// File: rtl/cluster_pwr_ctrl_chk.sv
module cluster_pwr_ctrl_chk #(
  parameter int NCL = 2,
  parameter int CPC = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic [4:0]           bus_addr,
  input logic [31:0]          bus_rdata,
  input logic [NCL*CPC-1:0]   core_standby,
  input logic [NCL-1:0]       cluster_standby,
  input logic [NCL*CPC-1:0]   wake_req,
  input logic [NCL*CPC-1:0]   core_pwr_en,
  input logic [NCL-1:0]       cluster_pwr_en,
  input logic                 prog_err
);

  localparam int NCORE = NCL * CPC;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err);

  assert_rdata_other_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 5'h10) |-> (bus_rdata == 32'd0));

  for (genvar k = 0; k < NCORE; k++) begin : g_core_chk
    assert_core_needs_cluster_R11: assert property (@(posedge clk) disable iff (!rst_n)
      core_pwr_en[k] |-> cluster_pwr_en[k / CPC]);

    assert_core_off_by_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_pwr_en[k]) |-> $past(core_standby[k] | cluster_standby[k / CPC]));

    assert_core_on_by_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pwr_en[k]) |-> $past(wake_req[k] | (bus_wr && (bus_addr == 5'h04))));
  end

  for (genvar c = 0; c < NCL; c++) begin : g_clus_chk
    assert_cluster_off_by_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cluster_pwr_en[c]) |-> $past(cluster_standby[c]));
  end

endmodule

bind cluster_pwr_ctrl cluster_pwr_ctrl_chk #(.NCL(NCL), .CPC(CPC)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_wr          (bus_wr),
  .bus_addr        (bus_addr),
  .bus_rdata       (bus_rdata),
  .core_standby    (core_standby),
  .cluster_standby (cluster_standby),
  .wake_req        (wake_req),
  .core_pwr_en     (core_pwr_en),
  .cluster_pwr_en  (cluster_pwr_en),
  .prog_err        (prog_err)
);

// File: tb/cluster_pwr_ctrl_tb.sv
module cluster_pwr_ctrl_tb;

  localparam int NCL   = 2;
  localparam int CPC   = 4;
  localparam int NCORE = NCL * CPC;

  logic              clk;
  logic              rst_n;
  logic              bus_wr;
  logic [4:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NCORE-1:0]  core_standby;
  logic [NCL-1:0]    cluster_standby;
  logic [NCORE-1:0]  wake_req;
  logic              warm_rst_req;
  logic [NCORE-1:0]  core_pwr_en;
  logic [NCL-1:0]    cluster_pwr_en;
  logic              prog_err;

  int n_chk;
  int n_err;
  int n_cyc;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  cluster_pwr_ctrl #(.NCL(NCL), .CPC(CPC)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .core_standby    (core_standby),
    .cluster_standby (cluster_standby),
    .wake_req        (wake_req),
    .warm_rst_req    (warm_rst_req),
    .core_pwr_en     (core_pwr_en),
    .cluster_pwr_en  (cluster_pwr_en),
    .prog_err        (prog_err)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_on   [NCORE];
  bit          m_pend [NCORE];
  bit          m_wen  [NCORE];
  int          m_rsn  [NCORE];
  bit          m_clon [NCL];
  bit          m_cpend[NCL];
  bit          m_err;
  logic [23:0] m_sel;

  function automatic bit id_decode(input logic [23:0] id, output int k, output int c);
    int core_f;
    core_f = int'(id[7:0]);
    c      = int'(id[15:8]);
    k      = c * CPC + core_f;
    return (id[23:16] == 8'd0) && (core_f < CPC) && (c < NCL);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCORE; i++) begin
      m_on[i] = (i == 0); m_pend[i] = 0; m_wen[i] = 0; m_rsn[i] = 0;
    end
    for (int i = 0; i < NCL; i++) begin
      m_clon[i] = (i == 0); m_cpend[i] = 0;
    end
    m_err = 0;
    m_sel = '0;
  endtask

  task automatic model_step();
    int k, c;
    bit ok;
    ok = id_decode(bus_wdata[23:0], k, c);
    if (bus_wr) begin
      case (bus_addr)
        5'h00: if (ok && m_on[k]) m_pend[k] = 1; else m_err = 1;
        5'h04: if (ok && !m_on[k]) begin
                 m_on[k] = 1; m_clon[c] = 1; m_pend[k] = 0; m_cpend[c] = 0; m_rsn[k] = 2;
               end else m_err = 1;
        5'h08: if (ok && m_clon[c]) m_cpend[c] = 1; else m_err = 1;
        5'h0C: if (ok) m_wen[k] = bus_wdata[31]; else m_err = 1;
        5'h10: m_sel = bus_wdata[23:0];
        default: ;
      endcase
    end
    for (int i = 0; i < NCORE; i++)
      if (wake_req[i] && m_wen[i] && !m_on[i]) begin
        m_on[i] = 1; m_pend[i] = 0; m_rsn[i] = 3;
        m_clon[i / CPC] = 1; m_cpend[i / CPC] = 0;
      end
    for (int i = 0; i < NCORE; i++)
      if (core_standby[i] && m_pend[i] && m_on[i]) begin
        m_on[i] = 0; m_pend[i] = 0;
      end
    for (int j = 0; j < NCL; j++)
      if (cluster_standby[j] && m_cpend[j] && m_clon[j]) begin
        m_clon[j] = 0; m_cpend[j] = 0;
        for (int i = j * CPC; i < (j + 1) * CPC; i++) begin
          m_on[i] = 0; m_pend[i] = 0;
        end
      end
    if (warm_rst_req)
      for (int i = 0; i < NCORE; i++) if (m_on[i]) m_rsn[i] = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  function automatic logic [31:0] model_status(input logic [23:0] sel);
    int k, c;
    if (!id_decode(sel, k, c)) return 32'd0;
    return {1'b0, m_clon[c], m_on[k], m_wen[k], m_cpend[c], m_pend[k], 2'(m_rsn[k]), 24'd0};
  endfunction

  task automatic model_cmp();
    logic [NCORE-1:0] e_core;
    logic [NCL-1:0]   e_cl;
    logic [31:0]      e_rd;
    for (int i = 0; i < NCORE; i++) e_core[i] = m_on[i];
    for (int j = 0; j < NCL; j++)   e_cl[j]   = m_clon[j];
    e_rd = (bus_addr == 5'h10) ? model_status(m_sel) : 32'd0;
    n_chk++;
    if (core_pwr_en !== e_core || cluster_pwr_en !== e_cl || prog_err !== m_err || bus_rdata !== e_rd) begin
      n_err++;
      $display("FAIL R11 model cycle %0d: core=%h/%h cluster=%b/%b err=%b/%b rdata=%h/%h (actual/expected)",
               n_cyc, core_pwr_en, e_core, cluster_pwr_en, e_cl, prog_err, m_err, bus_rdata, e_rd);
    end
  endtask

  // ---------------- bench helpers ----------------
  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", n_cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  task automatic idle();
    bus_wr = 0; bus_addr = 5'h10; bus_wdata = '0;
    core_standby = '0; cluster_standby = '0; wake_req = '0; warm_rst_req = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 0; bus_addr = 5'h10; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] sel, input logic [31:0] exp);
    wr(5'h10, {8'd0, sel});
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    repeat (4) cyc();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    n_chk = 0; n_err = 0; n_cyc = 0;
    idle();
    rst_n = 0;
    do_reset();

    // R1: reset state
    chk("R1 core_pwr_en", 32'(core_pwr_en), 32'h01);
    chk("R1 cluster_pwr_en", 32'(cluster_pwr_en), 32'h1);
    chk("R1 prog_err", 32'(prog_err), 32'h0);
    rd_chk("R1 status core0", 24'h000000, 32'h6000_0000);

    // R3: power on cluster 1 core 2 (index 6)
    wr(5'h04, 32'h0000_0102);
    chk("R3 core_pwr_en", 32'(core_pwr_en), 32'h41);
    chk("R3 cluster_pwr_en", 32'(cluster_pwr_en), 32'h3);
    rd_chk("R3 status reason 10", 24'h000102, 32'h6200_0000);

    // R4: deferred processor off
    wr(5'h00, 32'h0000_0102);
    chk("R4 still on while pending", 32'(core_pwr_en), 32'h41);
    #1 chk("R4 pending bit", bus_rdata, 32'h6600_0000);
    core_standby[6] = 1; cyc(); core_standby[6] = 0;
    chk("R4 off after standby", 32'(core_pwr_en), 32'h01);
    #1 chk("R4 status after off", bus_rdata, 32'h4200_0000);

    // R7: wake ignored without enable
    wake_req[6] = 1; cyc(); wake_req[6] = 0;
    chk("R7 wake ignored", 32'(core_pwr_en), 32'h01);

    // R6: wake enable via bit 31, upper bits 30:24 ignored
    wr(5'h0C, 32'hFF00_0102);
    #1 chk("R6 wake enable bit", bus_rdata, 32'h5200_0000);

    // R7: wake brings core back with reason 11
    wake_req[6] = 1; cyc(); wake_req[6] = 0;
    chk("R7 woken", 32'(core_pwr_en), 32'h41);
    #1 chk("R7 status reason 11", bus_rdata, 32'h7300_0000);

    // R5: cluster off deferred until cluster standby
    wr(5'h08, 32'h0000_0100);
    #1 chk("R5 cluster pending bit", bus_rdata, 32'h7B00_0000);
    cluster_standby[1] = 1; cyc(); cluster_standby[1] = 0;
    chk("R5 cluster off", 32'(cluster_pwr_en), 32'h1);
    chk("R5 cores of cluster off", 32'(core_pwr_en), 32'h01);
    #1 chk("R5 status after cluster off", bus_rdata, 32'h1300_0000);
    chk("R10 no error yet", 32'(prog_err), 32'h0);

    // R10: off request to an off core
    wr(5'h00, 32'h0000_0102);
    chk("R10 error on bad off", 32'(prog_err), 32'h1);
    chk("R10 state unchanged", 32'(core_pwr_en), 32'h01);
    repeat (3) cyc();
    chk("R10 error sticky", 32'(prog_err), 32'h1);

    // R2: invalid identifiers
    do_reset();
    wr(5'h04, 32'h0001_0001);
    chk("R2 nonzero top field ignored", 32'(core_pwr_en), 32'h01);
    chk("R2 error flagged", 32'(prog_err), 32'h1);
    wr(5'h04, 32'h7F00_0001);
    chk("R2 bits 30:24 ignored", 32'(core_pwr_en), 32'h03);
    rd_chk("R8 invalid selection reads zero", 24'h000004, 32'h0);
    bus_addr = 5'h04; #1;
    chk("R8 other address reads zero", bus_rdata, 32'h0);
    bus_addr = 5'h10;

    // R9: warm reset pin
    warm_rst_req = 1; cyc(); warm_rst_req = 0;
    rd_chk("R9 reason 01 on powered core", 24'h000001, 32'h6100_0000);
    rd_chk("R9 unpowered core keeps reason", 24'h000002, 32'h4000_0000);

    // R12: off write and standby in the same cycle
    core_standby[1] = 1;
    wr(5'h00, 32'h0000_0001);
    core_standby[1] = 0;
    chk("R12 same-cycle off", 32'(core_pwr_en), 32'h01);
    // R12: power-on with standby held stays on
    core_standby[1] = 1;
    wr(5'h04, 32'h0000_0001);
    cyc();
    core_standby[1] = 0;
    chk("R12 on survives standby", 32'(core_pwr_en), 32'h03);

    // Random phase, compared with the model every cycle (R11 and all others)
    do_reset();
    for (int n = 0; n < 6000; n++) begin
      int r;
      logic [7:0] cf, lf, tf;
      r  = $urandom % 100;
      cf = 8'($urandom % 5);
      lf = 8'($urandom % 3);
      tf = ($urandom % 16 == 0) ? 8'h01 : 8'h00;
      if (r < 35) begin
        bus_wr = 1;
        case ($urandom % 6)
          0: bus_addr = 5'h00;
          1: bus_addr = 5'h04;
          2: bus_addr = 5'h08;
          3: bus_addr = 5'h0C;
          4: bus_addr = 5'h10;
          default: bus_addr = 5'h14;
        endcase
        bus_wdata = {1'($urandom), 7'($urandom), tf, lf, cf};
      end else begin
        bus_wr = 0; bus_addr = ($urandom % 8 == 0) ? 5'h0C : 5'h10; bus_wdata = '0;
      end
      for (int i = 0; i < NCORE; i++) begin
        core_standby[i] = ($urandom % 6 == 0);
        wake_req[i]     = ($urandom % 8 == 0);
      end
      for (int j = 0; j < NCL; j++) cluster_standby[j] = ($urandom % 10 == 0);
      warm_rst_req = ($urandom % 40 == 0);
      if (n % 1500 == 1499) do_reset();
      else cyc();
    end
    idle();
    cyc();
    finish_run();
  end

endmodule